// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Core

This block keeps the time of day and the calendar date as packed-BCD bytes and advances them by one second at a time. A periodic tick input arrives `TICKS_PER_SEC` times per second. An internal sub-second phase counter turns those ticks into a one-second step. The step ripples through seconds, minutes, hours, day-of-week, day-of-month, month and a two-digit year. The hour byte runs either as a plain 00–23 count or as a 1–12 count with an AM/PM flag. The counter rolls correctly in both encodings.

Software, or a bus bridge outside this block, loads and reads back each byte through a simple parallel register port. Writing any time byte restarts the sub-second phase. The next advance therefore comes one full second after the load. A halt input freezes both the time and the phase. A one-cycle pulse marks each second step, and a square wave gated by an enable input gives a 1 Hz output.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset, the time bytes read seconds 00, minutes 00, hour 0x00 (24-hour mode), day-of-week 1, day-of-month 01, month 01 and year 00. Both `pps_o` and `sqw_o` are low.
- R2: Byte addresses 0 to 6 select seconds, minutes, hour, day-of-week, day-of-month, month and year, in that order. A write loads `wdata_i` at the next clock edge, and `rdata_o` shows the addressed byte combinationally. A write to address 7 changes no byte, and address 7 reads 0x00.
- R3: The time advances once every `TICKS_PER_SEC` accepted ticks. Seconds and minutes count BCD 00 to 59 and carry to the next byte on wrap. `pps_o` is high for exactly the one cycle in which the advanced time first shows.
- R4: In 24-hour mode (hour bit 6 clear), the hour counts BCD 00 to 23. The step from 23 goes to 00 and carries into the date.
- R5: In 12-hour mode, hour bit 6 is set and bit 5 marks PM, above a BCD hour 01 to 12 in bits 4:0. Hour 11 steps to 12 and toggles PM. Hour 12 steps to 01 without toggling. Only the step from 11 PM to 12 AM carries into the date.
- R6: Day-of-week counts 1 to 7 and wraps back to 1 on each date carry.
- R7: Day-of-month wraps to 01 after 31, or after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 28, or after 29 when the BCD year is a multiple of four (00 included).
- R8: Month counts 01 to 12 and wraps to 01 with a carry into the year. The year counts BCD 00 to 99 and wraps to 00.
- R9: While `osc_halt_i` is high, no time byte changes except by a register write, the sub-second phase holds, and `pps_o` stays low.
- R10: A write to any time byte clears the sub-second phase and suppresses any step in that cycle. The next advance then needs a full `TICKS_PER_SEC` ticks.
- R11: `sqw_o` is high when `sqw_en_i` is high and the sub-second phase is below `TICKS_PER_SEC/2`. It is low whenever `sqw_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second tick, one cycle wide, `TICKS_PER_SEC` per second |
| osc_halt_i | input | 1 | High freezes counting |
| sqw_en_i | input | 1 | Enables the square-wave output |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pps_o | output | 1 | One-cycle pulse on each second step |
| sqw_o | output | 1 | Gated 1 Hz square wave |

## Verification
A wrong carry or wrap decision shows in the byte readback in the same cycle as the faulty step, so it is caught one second of ticks after a boundary value is loaded. Each table vector loads a value just short of a boundary (second, hour in both encodings, month ends, leap February, century end) and compares all seven bytes after one step. A phase counter that is off by one shows as `pps_o` and `sqw_o` toggling on the wrong tick, and the directed halt, reload and square-wave tests check those tick by tick.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int NUM_TIME_REGS = 7;

  typedef enum logic [2:0] {
    ADR_SEC  = 3'd0,
    ADR_MIN  = 3'd1,
    ADR_HOUR = 3'd2,
    ADR_DOW  = 3'd3,
    ADR_DOM  = 3'd4,
    ADR_MON  = 3'd5,
    ADR_YEAR = 3'd6
  } time_adr_e;

  localparam int HOUR_MODE_BIT = 6;
  localparam int HOUR_PM_BIT   = 5;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // 10 mod 4 == 2, so value mod 4 == (2*tens + ones) mod 4
  function automatic logic year_is_leap(input logic [7:0] y);
    logic [1:0] m;
    m = {y[4], 1'b0} + y[1:0];
    return (m == 2'd0);
  endfunction
endpackage

// File: rtl/bcd_phase_div.sv
module bcd_phase_div #(
  parameter int TICKS_PER_SEC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic halt_i,
  input  logic clr_i,
  output logic step_o,
  output logic pps_o,
  output logic first_half_o
);
  localparam int PW   = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int LAST = TICKS_PER_SEC - 1;
  localparam int HALF = TICKS_PER_SEC / 2;

  logic [PW-1:0] phase_q;
  logic          adv;
  logic          pps_q;

  assign adv          = tick_i && !halt_i && !clr_i;
  assign step_o       = adv && (phase_q == PW'(LAST));
  assign first_half_o = (phase_q < PW'(HALF));
  assign pps_o        = pps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pps_q   <= 1'b0;
    end else begin
      pps_q <= step_o;
      if (clr_i)         phase_q <= '0;
      else if (step_o)   phase_q <= '0;
      else if (adv)      phase_q <= phase_q + PW'(1);
    end
  end
endmodule

// File: rtl/bcd_hour_step.sv
module bcd_hour_step
  import bcd_clock_pkg::*;
(
  input  logic [7:0] hour_i,
  output logic [7:0] hour_o,
  output logic       day_carry_o
);
  logic [7:0] low;
  logic [7:0] low_inc;
  logic       pm;

  assign low     = {3'b000, hour_i[4:0]};
  assign low_inc = bcd_inc(low);
  assign pm      = hour_i[HOUR_PM_BIT];

  always_comb begin
    hour_o      = 8'h00;
    day_carry_o = 1'b0;
    if (!hour_i[HOUR_MODE_BIT]) begin
      if (hour_i == 8'h23) begin
        hour_o      = 8'h00;
        day_carry_o = 1'b1;
      end else begin
        hour_o = bcd_inc(hour_i);
      end
    end else if (low == 8'h11) begin
      hour_o      = {2'b01, ~pm, 5'h12};
      day_carry_o = pm;
    end else if (low == 8'h12) begin
      hour_o = {2'b01, pm, 5'h01};
    end else begin
      hour_o = {2'b01, pm, low_inc[4:0]};
    end
  end
endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len
  import bcd_clock_pkg::*;
(
  input  logic [7:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_day_o
);
  always_comb begin
    unique case (mon_i)
      8'h02:                      last_day_o = year_is_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 2,
  parameter int ADDR_W        = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              osc_halt_i,
  input  logic              sqw_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              pps_o,
  output logic              sqw_o
);
  logic [7:0] sec_q, min_q, hour_q, dow_q, dom_q, mon_q, year_q;
  logic [7:0] hour_nx, last_day;
  logic       hour_carry, step, first_half, wr_hit;
  logic       sec_wrap, min_wrap, dom_wrap, mon_wrap;
  logic       min_en, hour_en, day_en, mon_en, year_en;

  assign wr_hit = wr_en_i && (addr_i < ADDR_W'(NUM_TIME_REGS));

  bcd_phase_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .halt_i      (osc_halt_i),
    .clr_i       (wr_hit),
    .step_o      (step),
    .pps_o       (pps_o),
    .first_half_o(first_half)
  );

  bcd_hour_step u_hour (
    .hour_i     (hour_q),
    .hour_o     (hour_nx),
    .day_carry_o(hour_carry)
  );

  bcd_month_len u_mlen (
    .mon_i     (mon_q),
    .year_i    (year_q),
    .last_day_o(last_day)
  );

  assign sec_wrap = (sec_q == 8'h59);
  assign min_wrap = (min_q == 8'h59);
  assign dom_wrap = (dom_q == last_day);
  assign mon_wrap = (mon_q == 8'h12);
  assign min_en   = step && sec_wrap;
  assign hour_en  = min_en && min_wrap;
  assign day_en   = hour_en && hour_carry;
  assign mon_en   = day_en && dom_wrap;
  assign year_en  = mon_en && mon_wrap;

  assign sqw_o = sqw_en_i && first_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      dow_q  <= 8'h01;
      dom_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_hit) begin
      unique case (addr_i[2:0])
        ADR_SEC:  sec_q  <= wdata_i;
        ADR_MIN:  min_q  <= wdata_i;
        ADR_HOUR: hour_q <= wdata_i;
        ADR_DOW:  dow_q  <= wdata_i;
        ADR_DOM:  dom_q  <= wdata_i;
        ADR_MON:  mon_q  <= wdata_i;
        default:  year_q <= wdata_i;
      endcase
    end else begin
      if (step)    sec_q  <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (min_en)  min_q  <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (hour_en) hour_q <= hour_nx;
      if (day_en) begin
        dow_q <= (dow_q >= 8'h07) ? 8'h01 : dow_q + 8'h01;
        dom_q <= dom_wrap ? 8'h01 : bcd_inc(dom_q);
      end
      if (mon_en)  mon_q  <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
      if (year_en) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i < ADDR_W'(NUM_TIME_REGS)) begin
      unique case (addr_i[2:0])
        ADR_SEC:  rdata_o = sec_q;
        ADR_MIN:  rdata_o = min_q;
        ADR_HOUR: rdata_o = hour_q;
        ADR_DOW:  rdata_o = dow_q;
        ADR_DOM:  rdata_o = dom_q;
        ADR_MON:  rdata_o = mon_q;
        default:  rdata_o = year_q;
      endcase
    end
  end
endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              osc_halt_i,
  input logic              sqw_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              pps_o,
  input logic              sqw_o,
  input logic [7:0]        sec_q,
  input logic [7:0]        min_q,
  input logic [7:0]        hour_q,
  input logic [7:0]        dom_q
);
  // R9
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_halt_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(dom_q) && !pps_o));

  // R3
  pps_moves_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_o |-> (sec_q != $past(sec_q)));

  // R3
  pps_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_o |=> !pps_o);

  // R2
  sec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(0)) |=> (sec_q == $past(wdata_i)));

  // R5
  hour_mode_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (hour_q[6] == $past(hour_q[6])));

  // R11
  sqw_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqw_en_i |-> !sqw_o);
endmodule

bind bcd_clock_core bcd_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .osc_halt_i(osc_halt_i),
  .sqw_en_i  (sqw_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pps_o     (pps_o),
  .sqw_o     (sqw_o),
  .sec_q     (sec_q),
  .min_q     (min_q),
  .hour_q    (hour_q),
  .dom_q     (dom_q)
);

// File: tb/bcd_clock_core_tb.sv
module bcd_clock_core_tb;
  localparam int TPS    = 2;
  localparam int AW     = 3;
  localparam int NVEC   = 18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic          osc_halt_i = 1'b0;
  logic          sqw_en_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic          pps_o;
  logic          sqw_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  bcd_clock_core #(.TICKS_PER_SEC(TPS), .ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .osc_halt_i(osc_halt_i),
    .sqw_en_i(sqw_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pps_o(pps_o), .sqw_o(sqw_o)
  );

  // {load bytes, expected bytes}; byte order sec,min,hour,dow,dom,mon,year
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h00000001010100, 56'h01000001010100}, // R3 plain second
    {56'h59090002050610, 56'h00100002050610}, // R3 minute carry
    {56'h59592307150324, 56'h00000001160324}, // R4 R6 day carry, dow 7->1
    {56'h59595103100425, 56'h00007203100425}, // R5 11 AM -> 12 PM
    {56'h59597203100425, 56'h00006103100425}, // R5 12 PM -> 1 PM
    {56'h59597103100425, 56'h00005204110425}, // R5 11 PM -> 12 AM, date carry
    {56'h59595203100425, 56'h00004103100425}, // R5 12 AM -> 1 AM
    {56'h59592302280223, 56'h00000003010323}, // R7 Feb 28 non-leap
    {56'h59592302280224, 56'h00000003290224}, // R7 Feb 28 leap
    {56'h59592304290224, 56'h00000005010324}, // R7 Feb 29 leap
    {56'h59592301300425, 56'h00000002010525}, // R7 30-day month
    {56'h59592305310125, 56'h00000006010225}, // R7 31-day month
    {56'h59592306311299, 56'h00000007010100}, // R8 year 99 -> 00
    {56'h59592301280200, 56'h00000002290200}, // R7 year 00 leap
    {56'h59590901010101, 56'h00001001010101}, // R3 hour BCD digit carry
    {56'h59592303301112, 56'h00000004011212}, // R7 Nov 30
    {56'h59592303300125, 56'h00000004310125}, // R7 30 in a 31-day month
    {56'h59596901050505, 56'h00007001050505}  // R5 9 PM -> 10 PM
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1, 14:           return "R3";
      2:                  return "R4 R6";
      3, 4, 5, 6, 17:     return "R5";
      12:                 return "R8";
      default:            return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = AW'(a);
    #1 d = rdata_o;
  endtask

  task automatic rd_all(output logic [55:0] v);
    logic [7:0] b;
    for (int k = 0; k < 7; k++) begin
      rd(k, b);
      v[55-8*k -: 8] = b;
    end
  endtask

  task automatic wr_all(input logic [55:0] v);
    for (int k = 0; k < 7; k++) wr(k, v[55-8*k -: 8]);
  endtask

  // leaves sampling point at the negedge after the tick edge
  task automatic tick(output logic p);
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    p = pps_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [55:0] v;
    logic [7:0]  b;
    logic        p;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 pps", pps_o, 1'b0);
    check("R1 sqw", sqw_o, 1'b0);
    rd_all(v);
    check("R1 bytes", v, 56'h00000001010100);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      wr_all(VEC[i][111:56]);
      for (int t = 0; t < TPS - 1; t++) begin
        tick(p);
        check("R3 no early pps", p, 1'b0);
      end
      tick(p);
      check("R3 pps on step", p, 1'b1);
      @(negedge clk_i);
      check("R3 pps one cycle", pps_o, 1'b0);
      rd_all(v);
      check(vec_req(i), v, VEC[i][55:0]);
    end

    // R2 readback and ignored address 7
    wr_all(56'h12345603170788);
    rd_all(v);
    check("R2 readback", v, 56'h12345603170788);
    wr(7, 8'hAA);
    rd_all(v);
    check("R2 addr7 write ignored", v, 56'h12345603170788);
    rd(7, b);
    check("R2 addr7 reads zero", b, 8'h00);

    // R9 halt freezes time and phase
    wr(0, 8'h10);
    tick(p);
    osc_halt_i = 1'b1;
    for (int t = 0; t < 4; t++) begin
      tick(p);
      check("R9 no pps while halted", p, 1'b0);
    end
    rd(0, b);
    check("R9 seconds frozen", b, 8'h10);
    osc_halt_i = 1'b0;
    tick(p);
    check("R9 phase held, step on resume", p, 1'b1);
    rd(0, b);
    check("R9 seconds after resume", b, 8'h11);

    // R10 write clears phase
    wr(0, 8'h20);
    tick(p);
    wr(0, 8'h30);
    tick(p);
    check("R10 no step after reload", p, 1'b0);
    rd(0, b);
    check("R10 seconds held", b, 8'h30);
    tick(p);
    check("R10 step after full second", p, 1'b1);
    rd(0, b);
    check("R10 seconds advanced", b, 8'h31);

    // R11 square wave
    sqw_en_i = 1'b1;
    wr(0, 8'h00);
    #1 check("R11 high in first half", sqw_o, 1'b1);
    tick(p);
    #1 check("R11 low in second half", sqw_o, 1'b0);
    tick(p);
    #1 check("R11 high again", sqw_o, 1'b1);
    sqw_en_i = 1'b0;
    #1 check("R11 gated off", sqw_o, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule